// File: doc/BRIEF.md
# Reference Activity and Frequency Classifier

This block watches a bank of reference clock inputs and one cross-couple reference, all presented as edge strobes that are already synchronized to the local system clock. A strobe is one clock cycle high for each rising edge of the reference. A free-running gate timer splits local time into windows of `GATE_CYCLES` cycles. During each window the block notes whether every bank reference showed any edge at all. For the cross-couple input it counts the edges, and at the end of the window it matches the count against a tolerance band around the expected count of each supported telecom rate.

Results do not reach the outputs at once. A result is accepted only when two consecutive windows agree, so a single disturbed window leaves the outputs unchanged. When a result is accepted, the status outputs change and one-cycle event pulses mark every activity bit that rose or fell. The cross-couple input has separate appear and disappear events. The expected count of each rate is worked out at elaboration from the local clock rate (`CLK_KHZ`) and the window length. The default 155.52 MHz clock with a 1 ms window gives 8 edges for the 8 kHz rate and 77,760 edges for the top rate.

Top module: `ref_activity_classifier`

## Requirements
- R1: After acceptance, `ref_act[i]` is 1 when bank input i carried at least one strobe in the window, including a strobe in the window's last cycle, and 0 when it carried none.
- R2: The nominal count of a rate is round(rate_kHz * GATE_CYCLES / CLK_KHZ), and its band is nominal ± floor(nominal * BAND_PCT / 100). A cross-couple count inside a band gives `xref_act`=1 and one of these `xref_code` values: 8 kHz gives 4'b0001, 12.96 MHz gives 4'b0100, 19.44 MHz gives 4'b0101, 25.92 MHz gives 4'b0110, 38.88 MHz gives 4'b0111, 51.84 MHz gives 4'b1000 and 77.76 MHz gives 4'b1001.
- R3: A cross-couple window with zero strobes gives `xref_act`=0 and `xref_code`=4'b0000.
- R4: A non-zero cross-couple count that lies outside every band gives `xref_act`=0 and keeps the `xref_code` accepted before.
- R5: `xref_code` never takes the values 4'b0010, 4'b0011 or 4'b1010 to 4'b1111, and `xref_act`=1 never appears together with 4'b0000.
- R6: Status outputs change, and event pulses appear, only in the cycle after the clock edge that closes a window. The first window is the `GATE_CYCLES` rising edges that follow the release of reset.
- R7: A new result, whether for one bank bit or for the whole cross-couple activity/code pair, is accepted only when it is the same in two consecutive windows. A result seen in a single window has no effect on the outputs.
- R8: `xref_up` is high for exactly one cycle when `xref_act` goes from 0 to 1, and `xref_down` is high for exactly one cycle when it goes from 1 to 0. The pulse falls in the same cycle as the new status. A change of code alone raises neither pulse.
- R9: `ref_up[i]` and `ref_down[i]` pulse for one cycle when `ref_act[i]` rises or falls, in the same cycle as the new status.
- R10: A synchronous active-high `rst` clears every output to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge | input | NUM_REFS | Edge strobes of the bank references, at most one per cycle |
| xref_edge | input | 1 | Edge strobe of the cross-couple reference |
| ref_act | output | NUM_REFS | Accepted activity bit per bank reference |
| ref_up | output | NUM_REFS | One-cycle pulse when a bank bit rises |
| ref_down | output | NUM_REFS | One-cycle pulse when a bank bit falls |
| xref_act | output | 1 | Cross-couple count lies in a supported band |
| xref_code | output | 4 | Cross-couple rate code |
| xref_up | output | 1 | One-cycle pulse when cross-couple activity appears |
| xref_down | output | 1 | One-cycle pulse when cross-couple activity disappears |

## Verification
The cross-couple rate decision and the bank-presence decision are accepted at the same window edge. A cross-couple appear or disappear pulse can therefore fall in the same cycle as several bank rise and fall pulses. The bench provokes this by changing the cross-couple rate and the bank pattern on the same window boundary. It runs the supported rates, an out-of-band rate and a silent input, and places single-window disturbances on both paths. Each window's result is judged against an arithmetic model of the bands and of the two-window agreement, checked at the negedge after the closing edge and again one cycle later, when the pulses must be gone.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  localparam int unsigned NUM_RATES = 7;
  localparam int unsigned CODE_W    = 4;

  typedef logic [CODE_W-1:0] rate_code_t;

  localparam rate_code_t CODE_NONE = 4'd0;

  // Supported cross-couple rates in kHz, one entry per band
  function automatic longint unsigned rate_khz(input int unsigned idx);
    case (idx)
      0:       return 64'd8;
      1:       return 64'd12960;
      2:       return 64'd19440;
      3:       return 64'd25920;
      4:       return 64'd38880;
      5:       return 64'd51840;
      6:       return 64'd77760;
      default: return 64'd0;
    endcase
  endfunction

  // Code reported for each band (nonlinear: 2 and 3 are skipped)
  function automatic rate_code_t rate_code(input int unsigned idx);
    case (idx)
      0:       return 4'd1;
      1:       return 4'd4;
      2:       return 4'd5;
      3:       return 4'd6;
      4:       return 4'd7;
      5:       return 4'd8;
      6:       return 4'd9;
      default: return CODE_NONE;
    endcase
  endfunction

  // Edges expected in one window, rounded to nearest
  function automatic longint unsigned nominal_count(input int unsigned idx,
                                                    input longint unsigned gate,
                                                    input longint unsigned clk_khz);
    return (rate_khz(idx) * gate + clk_khz / 2) / clk_khz;
  endfunction

endpackage

// File: rtl/refmon_gate_timer.sv
module refmon_gate_timer #(
  parameter int unsigned GATE_CYCLES = 155520
) (
  input  logic clk,
  input  logic rst,
  output logic win_end
);
  localparam int unsigned TW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

  logic [TW-1:0] cnt;

  assign win_end = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (win_end) cnt <= '0;
    else              cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/refmon_edge_counter.sv
module refmon_edge_counter #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_end,
  input  logic             edge_in,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] cnt;

  // Running count including the current cycle's strobe
  assign total = cnt + CNT_W'(edge_in);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (win_end) cnt <= '0;
    else              cnt <= total;
  end
endmodule

// File: rtl/refmon_rate_classifier.sv
module refmon_rate_classifier
  import refmon_pkg::*;
#(
  parameter int unsigned GATE_CYCLES = 155520,
  parameter int unsigned CLK_KHZ     = 155520,
  parameter int unsigned BAND_PCT    = 1,
  parameter int unsigned CNT_W       = 18
) (
  input  logic [CNT_W-1:0] count,
  input  rate_code_t       held_code,
  output logic             sample_act,
  output rate_code_t       sample_code
);
  logic [NUM_RATES-1:0] hit;
  logic [63:0]          count_x;

  assign count_x = 64'(count);

  for (genvar k = 0; k < NUM_RATES; k++) begin : g_band
    localparam longint unsigned NOM = nominal_count(k, 64'(GATE_CYCLES), 64'(CLK_KHZ));
    localparam longint unsigned TOL = NOM * 64'(BAND_PCT) / 64'd100;
    localparam logic [63:0]     LO  = 64'(NOM - TOL);
    localparam logic [63:0]     HI  = 64'(NOM + TOL);
    if (NOM == 0) begin : g_off
      // Rate too slow to show an edge in one window: band disabled
      assign hit[k] = 1'b0;
    end else begin : g_on
      assign hit[k] = (count_x >= LO) && (count_x <= HI);
    end
  end

  always_comb begin
    sample_act  = 1'b0;
    sample_code = (count == '0) ? CODE_NONE : held_code;
    for (int unsigned k = 0; k < NUM_RATES; k++) begin
      if (hit[k]) begin
        sample_act  = 1'b1;
        sample_code = rate_code(k);
      end
    end
  end
endmodule

// File: rtl/refmon_confirm.sv
module refmon_confirm #(
  parameter int unsigned W       = 1,
  parameter int unsigned EVT_BIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         win_end,
  input  logic [W-1:0] sample,
  output logic [W-1:0] q,
  output logic         rise,
  output logic         fall
);
  logic [W-1:0] cand;
  logic         agree;

  assign agree = (sample == cand);

  always_ff @(posedge clk) begin
    if (rst) begin
      cand <= '0;
      q    <= '0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (win_end) begin
        cand <= sample;
        if (agree) begin
          q    <= sample;
          rise <= sample[EVT_BIT] & ~q[EVT_BIT];
          fall <= ~sample[EVT_BIT] & q[EVT_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/ref_activity_classifier.sv
module ref_activity_classifier
  import refmon_pkg::*;
#(
  parameter int unsigned NUM_REFS    = 8,
  parameter int unsigned CLK_KHZ     = 155520,
  parameter int unsigned GATE_CYCLES = 155520,
  parameter int unsigned BAND_PCT    = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REFS-1:0] ref_edge,
  input  logic                xref_edge,
  output logic [NUM_REFS-1:0] ref_act,
  output logic [NUM_REFS-1:0] ref_up,
  output logic [NUM_REFS-1:0] ref_down,
  output logic                xref_act,
  output logic [3:0]          xref_code,
  output logic                xref_up,
  output logic                xref_down
);
  localparam int unsigned CNT_W = $clog2(GATE_CYCLES + 1);
  localparam int unsigned XW    = CODE_W + 1;

  logic             win_end;
  logic [CNT_W-1:0] xcount;
  logic             s_act;
  rate_code_t       s_code;
  logic [XW-1:0]    xstat;

  refmon_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk(clk), .rst(rst), .win_end(win_end)
  );

  // Cross-couple path: count, classify, confirm
  refmon_edge_counter #(.CNT_W(CNT_W)) u_xcnt (
    .clk(clk), .rst(rst), .win_end(win_end), .edge_in(xref_edge), .total(xcount)
  );

  refmon_rate_classifier #(
    .GATE_CYCLES(GATE_CYCLES), .CLK_KHZ(CLK_KHZ),
    .BAND_PCT(BAND_PCT), .CNT_W(CNT_W)
  ) u_class (
    .count(xcount), .held_code(xstat[CODE_W-1:0]),
    .sample_act(s_act), .sample_code(s_code)
  );

  refmon_confirm #(.W(XW), .EVT_BIT(CODE_W)) u_xconf (
    .clk(clk), .rst(rst), .win_end(win_end), .sample({s_act, s_code}),
    .q(xstat), .rise(xref_up), .fall(xref_down)
  );

  assign xref_act  = xstat[CODE_W];
  assign xref_code = xstat[CODE_W-1:0];

  // Bank path: presence flag per reference, then confirm
  for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
    logic seen;
    logic present;

    always_ff @(posedge clk) begin
      if (rst || win_end) seen <= 1'b0;
      else if (ref_edge[i]) seen <= 1'b1;
    end

    assign present = seen | ref_edge[i];

    refmon_confirm #(.W(1), .EVT_BIT(0)) u_rconf (
      .clk(clk), .rst(rst), .win_end(win_end), .sample(present),
      .q(ref_act[i]), .rise(ref_up[i]), .fall(ref_down[i])
    );
  end
endmodule

// File: rtl/ref_activity_checker.sv
module ref_activity_checker #(
  parameter int unsigned NUM_REFS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                win_end,
  input logic [NUM_REFS-1:0] ref_act,
  input logic [NUM_REFS-1:0] ref_up,
  input logic [NUM_REFS-1:0] ref_down,
  input logic                xref_act,
  input logic [3:0]          xref_code,
  input logic                xref_up,
  input logic                xref_down
);
  // R5: reserved and unused codes never appear
  p_code_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (xref_code <= 4'd9) && (xref_code != 4'd2) && (xref_code != 4'd3));

  // R5: an active input always carries a rate code
  p_active_code_r5: assert property (@(posedge clk) disable iff (rst)
    xref_act |-> (xref_code != 4'd0));

  // R6: status holds between window closings
  p_quiet_between_r6: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> ($stable(xref_act) && $stable(xref_code) && $stable(ref_act)));

  // R6: events only right after a window closes
  p_events_at_close_r6: assert property (@(posedge clk) disable iff (rst)
    (xref_up || xref_down || (|ref_up) || (|ref_down)) |-> $past(win_end));

  // R8: appear / disappear pulses track activity edges
  p_xref_up_r8: assert property (@(posedge clk) disable iff (rst)
    xref_up == (xref_act && !$past(xref_act)));
  p_xref_down_r8: assert property (@(posedge clk) disable iff (rst)
    xref_down == (!xref_act && $past(xref_act)));

  // R9: per-reference pulses track bit edges
  p_ref_up_r9: assert property (@(posedge clk) disable iff (rst)
    ref_up == (ref_act & ~$past(ref_act)));
  p_ref_down_r9: assert property (@(posedge clk) disable iff (rst)
    ref_down == (~ref_act & $past(ref_act)));
endmodule

bind ref_activity_classifier ref_activity_checker #(.NUM_REFS(NUM_REFS)) u_chk (
  .clk(clk), .rst(rst), .win_end(win_end),
  .ref_act(ref_act), .ref_up(ref_up), .ref_down(ref_down),
  .xref_act(xref_act), .xref_code(xref_code),
  .xref_up(xref_up), .xref_down(xref_down)
);

// File: tb/ref_activity_classifier_tb_top.sv
module ref_activity_classifier_tb_top;
  localparam int N    = 8;
  localparam int GATE = 9720;
  localparam int SYS  = 77760;
  localparam int PCT  = 1;
  localparam int NW   = 20;

  localparam longint unsigned RATES [7] = '{8, 12960, 19440, 25920, 38880, 51840, 77760};
  localparam logic [3:0]      CODES [7] = '{4'd1, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] ref_edge = '0;
  logic         xref_edge = 1'b0;
  logic [N-1:0] ref_act, ref_up, ref_down;
  logic         xref_act, xref_up, xref_down;
  logic [3:0]   xref_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // model state
  logic [N-1:0] m_q = '0, m_cand = '0;
  logic         m_xa = 1'b0, m_ca = 1'b0;
  logic [3:0]   m_xc = 4'd0, m_cc = 4'd0;

  always #4 clk = ~clk;

  ref_activity_classifier #(
    .NUM_REFS(N), .CLK_KHZ(SYS), .GATE_CYCLES(GATE), .BAND_PCT(PCT)
  ) dut_i (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .xref_edge(xref_edge),
    .ref_act(ref_act), .ref_up(ref_up), .ref_down(ref_down),
    .xref_act(xref_act), .xref_code(xref_code),
    .xref_up(xref_up), .xref_down(xref_down)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic longint unsigned xk_of(input int w);
    case (w)
      1, 2:   return 8;
      3, 4:   return 12960;
      5, 6:   return 19440;
      7, 8:   return 25920;
      9, 10:  return 38880;
      11, 12: return 51840;
      13, 14: return 77760;
      15, 16: return 15000;
      17:     return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [N-1:0] refs_of(input int w);
    case (w)
      1, 2:       return 8'h09;
      3:          return 8'hF0;
      4:          return 8'hF1;
      5, 6:       return 8'hFF;
      9, 10:      return 8'h55;
      11, 12:     return 8'hAA;
      13, 14:     return 8'h81;
      15, 16, 17: return 8'h7E;
      18, 19:     return 8'h3C;
      default:    return 8'h00;
    endcase
  endfunction

  task automatic classify(input longint unsigned c, input logic [3:0] held,
                          output logic a, output logic [3:0] code);
    a    = 1'b0;
    code = (c == 0) ? 4'd0 : held;
    for (int k = 0; k < 7; k++) begin
      longint unsigned n = (RATES[k] * GATE + SYS / 2) / SYS;
      longint unsigned t = n * PCT / 100;
      if (n != 0 && c >= n - t && c <= n + t) begin
        a    = 1'b1;
        code = CODES[k];
      end
    end
  endtask

  task automatic run_window(input int w);
    longint unsigned fk = xk_of(w);
    logic [N-1:0]    pat = refs_of(w);
    longint unsigned acc [N+1];
    longint unsigned c;
    logic            s_a, commit_x, e_up, e_dn;
    logic [3:0]      s_c, code_before;
    logic [N-1:0]    agree, e_rup, e_rdn;
    string           xtag, rtag;
    for (int k = 0; k <= N; k++) acc[k] = 0;
    for (int i = 0; i < GATE; i++) begin
      for (int k = 0; k <= N; k++) begin
        longint unsigned r = (k < N) ? (pat[k] ? longint'(8 * (k + 1)) : 0) : fk;
        logic s = 1'b0;
        acc[k] = acc[k] + r;
        if (acc[k] >= SYS) begin
          s = 1'b1;
          acc[k] = acc[k] - SYS;
        end
        if (k < N) ref_edge[k] = s;
        else       xref_edge = s;
      end
      @(negedge clk);
      if (i == 0) begin
        // R6: one cycle into the window, pulses gone and status unchanged
        chk("R6 events", {xref_up, xref_down, ref_up, ref_down}, 32'd0);
        chk("R6 status", {xref_act, xref_code, ref_act}, {m_xa, m_xc, m_q});
      end
    end
    // model of the window result
    c = fk * GATE / SYS;
    code_before = m_xc;
    classify(c, code_before, s_a, s_c);
    commit_x = ({s_a, s_c} == {m_ca, m_cc});
    e_up = commit_x && s_a && !m_xa;
    e_dn = commit_x && !s_a && m_xa;
    xtag = s_a ? "R2" : ((c == 0) ? "R3" : "R4");
    if (!commit_x && ({s_a, s_c} != {m_xa, m_xc})) xtag = "R7";
    if (commit_x) begin
      m_xa = s_a;
      m_xc = s_c;
    end
    m_ca = s_a;
    m_cc = s_c;

    agree = ~(pat ^ m_cand);
    e_rup = agree & pat & ~m_q;
    e_rdn = agree & ~pat & m_q;
    rtag  = (|(~agree & (pat ^ m_q))) ? "R7" : "R1";
    m_q    = (m_q & ~agree) | (pat & agree);
    m_cand = pat;

    chk(rtag, ref_act, m_q);
    chk("R9 up", ref_up, e_rup);
    chk("R9 down", ref_down, e_rdn);
    chk({xtag, " act"}, xref_act, m_xa);
    chk({xtag, " code"}, xref_code, m_xc);
    chk("R8 up", xref_up, e_up);
    chk("R8 down", xref_down, e_dn);
    chk("R5", ((xref_code <= 4'd9) && (xref_code != 4'd2) && (xref_code != 4'd3)), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10", {xref_act, xref_code, xref_up, xref_down}, 32'd0);
    chk("R10", {ref_act, ref_up, ref_down}, 32'd0);
    rst = 1'b0;
    for (int w = 0; w < NW; w++) run_window(w);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (199500) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule